// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is the host-side sequencer for a 12-bit successive-approximation converter that has a parallel output bus. A conversion is started when the host asks for one, or the block runs conversions back to back in free-running mode. The sequencer drives the converter's active-low select, its read/convert line and its byte-select line. It watches the converter's active-low busy line through a two-flop synchroniser. It reads the result and returns it as a 12-bit sample with a one-cycle valid strobe.

A read takes one of two forms. In word mode the converter is read once over all 16 bus bits. In byte mode the block reads only the upper bus byte, twice: the first pass with byte-select low and the second with byte-select high. It then joins the two halves into one sample. The select lines are always back high before the converter can report completion, so a finished conversion cannot start a second one by accident. If busy does not complete its low-then-high cycle within a set number of clocks, a sticky timeout flag is raised and the sequencer goes back to idle.

The states are IDLE, CONVERT, WAIT_FALL, WAIT_RISE, READ_HI, READ_LO and DONE.

The transitions are:
- IDLE to CONVERT on a start request or in free-running mode.
- CONVERT to WAIT_FALL after the pulse width.
- WAIT_FALL to WAIT_RISE when the synchronised busy line is seen low.
- WAIT_RISE to READ_HI when it is seen high.
- READ_HI to READ_LO (byte mode) or to DONE (word mode) after the setup delay.
- READ_LO to DONE after the setup delay.
- DONE to IDLE.
- Either wait state to IDLE on timeout.

Top module: `adc_par_host`

## Requirements
- R1: While reset is asserted and right after it, cs_n_o=1, rc_o=1, byte_sel_o=0, sample_valid_o=0 and timeout_o=0.
- R2: A conversion is started by holding cs_n_o=0 and rc_o=0 together for exactly PULSE_W clock cycles (default 2).
- R3: At the moment busy_n_i rises, cs_n_o or rc_o is 1. After the convert pulse, both lines stay high until the result is read.
- R4: A read (cs_n_o=0 with rc_o=1) starts only after the synchronised busy_n_i has been seen low and then high again. No read happens while busy_n_i is low.
- R5: In word mode (byte_mode_i=0), byte_sel_o stays 0 and sample_o equals bus_i[15:4]. The bus is captured after SETUP_W read cycles (default 2).
- R6: In byte mode (byte_mode_i=1), the block makes a first read with byte_sel_o=0 and then a second read with byte_sel_o=1, each lasting SETUP_W cycles. sample_o = {first bus_i[15:8], second bus_i[15:12]}. byte_sel_o is 1 only during the second read.
- R7: sample_valid_o is high for exactly one cycle per completed conversion, with sample_o valid in that cycle.
- R8: start_i is accepted only in IDLE. A request made while a conversion is in progress starts no extra conversion.
- R9: With free_run_i=1, conversions repeat without start_i, each returning a valid sample.
- R10: If the wait for busy_n_i takes TIMEOUT_CYC cycles after the convert pulse, the sequencer does three things. It raises timeout_o, returns to IDLE with cs_n_o=1 and rc_o=1, and clears timeout_o when the next conversion is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion (taken in IDLE only) |
| free_run_i | input | 1 | Run conversions back to back while high |
| byte_mode_i | input | 1 | 1 = two 8-bit reads, 0 = one word read; latched at conversion start |
| busy_n_i | input | 1 | Converter busy, low while converting (asynchronous) |
| bus_i | input | 16 | Converter data bus |
| cs_n_o | output | 1 | Converter select, active low |
| rc_o | output | 1 | Read/convert: low = convert, high = read |
| byte_sel_o | output | 1 | Byte select for the swapped byte read |
| sample_o | output | 12 | Last assembled sample |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| timeout_o | output | 1 | Sticky flag: busy did not complete in time |

## Verification
Some rules are checked by the assertions on every cycle:
- the select-high rule at the busy rising edge;
- the single-cycle valid strobe;
- that a read begins only with synchronised busy high;
- that byte select rises only inside a read;
- that a convert pulse is only ever issued from IDLE;
- that the timeout flag rises only with both select lines high.

Other behaviour is shown only by the bench's scenarios against a converter model. This covers the exact pulse width, the bit mapping in word mode and the byte-swap assembly, the start requests that are ignored, repeated free-running conversions, and the timing window and clearing of the timeout flag.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_WAIT_FALL,
        ST_WAIT_RISE,
        ST_READ_HI,
        ST_READ_LO,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic rc;
        logic bsel;
    } pin_drive_t;

    localparam pin_drive_t PINS_QUIET = '{cs_n: 1'b1, rc: 1'b1, bsel: 1'b0};

    function automatic pin_drive_t pins_for(input ctl_state_e s);
        pin_drive_t p;
        p = PINS_QUIET;
        unique case (s)
            ST_CONVERT: begin
                p.cs_n = 1'b0;
                p.rc   = 1'b0;
            end
            ST_READ_HI: begin
                p.cs_n = 1'b0;
                p.rc   = 1'b1;
            end
            ST_READ_LO: begin
                p.cs_n = 1'b0;
                p.rc   = 1'b1;
                p.bsel = 1'b1;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adc_host_sync.sv
`timescale 1ns/1ps
module adc_host_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_host_tick.sv
`timescale 1ns/1ps
module adc_host_tick #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;

    assign hit_o = (cnt_q == limit_i - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && !hit_o) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // The count saturates at its terminal value and never runs past it.
    assert_tick_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/adc_host_assemble.sv
`timescale 1ns/1ps
module adc_host_assemble #(
    parameter int BUS_W = 16,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_word_i,
    input  logic             cap_hi_i,
    input  logic             cap_lo_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [RES_W-1:0] sample_o
);
    localparam int BYTE_W = 8;
    localparam int LO_W   = RES_W - BYTE_W;

    logic [BYTE_W-1:0] hi_q;
    logic [RES_W-1:0]  sample_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= '0;
            sample_q <= '0;
        end else begin
            if (cap_word_i) begin
                sample_q <= bus_i[BUS_W-1 -: RES_W];
            end
            if (cap_hi_i) begin
                hi_q <= bus_i[BUS_W-1 -: BYTE_W];
            end
            if (cap_lo_i) begin
                sample_q <= {hi_q, bus_i[BUS_W-1 -: LO_W]};
            end
        end
    end

    assign sample_o = sample_q;

    // At most one capture source is active in any cycle.
    assert_one_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_word_i, cap_hi_i, cap_lo_i}));

endmodule

// File: rtl/adc_par_host.sv
`timescale 1ns/1ps
module adc_par_host
    import adc_host_pkg::*;
#(
    parameter int PULSE_W     = 2,
    parameter int SETUP_W     = 2,
    parameter int TIMEOUT_CYC = 1024,
    parameter int BUS_W       = 16,
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             free_run_i,
    input  logic             byte_mode_i,
    input  logic             busy_n_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             cs_n_o,
    output logic             rc_o,
    output logic             byte_sel_o,
    output logic [RES_W-1:0] sample_o,
    output logic             sample_valid_o,
    output logic             timeout_o
);
    localparam int PH_MAX = (PULSE_W > SETUP_W) ? PULSE_W : SETUP_W;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

    ctl_state_e state_q, state_nxt;
    logic       ready_s;
    logic       mode_q;
    logic       timeout_q;
    logic       valid_q;
    pin_drive_t pins_q;

    logic            ph_hit, ph_clr, ph_en;
    logic [PH_W-1:0] ph_limit;
    logic            to_hit, to_clr, to_en;
    logic            accept;
    logic            cap_word, cap_hi, cap_lo;
    logic            waiting;

    adc_host_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (busy_n_i),
        .q_o   (ready_s)
    );

    assign ph_limit = (state_q == ST_CONVERT) ? PH_W'(PULSE_W) : PH_W'(SETUP_W);
    assign ph_en    = (state_q == ST_CONVERT) || (state_q == ST_READ_HI) || (state_q == ST_READ_LO);
    assign ph_clr   = (state_nxt != state_q);

    adc_host_tick #(.W(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ph_clr),
        .en_i    (ph_en),
        .limit_i (ph_limit),
        .hit_o   (ph_hit)
    );

    assign waiting = (state_q == ST_WAIT_FALL) || (state_q == ST_WAIT_RISE);
    assign to_clr  = (state_q == ST_CONVERT);
    assign to_en   = waiting;

    adc_host_tick #(.W(TO_W)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (to_clr),
        .en_i    (to_en),
        .limit_i (TO_W'(TIMEOUT_CYC)),
        .hit_o   (to_hit)
    );

    assign accept = (state_q == ST_IDLE) && (start_i || free_run_i);

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i || free_run_i) state_nxt = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (ph_hit) state_nxt = ST_WAIT_FALL;
            end
            ST_WAIT_FALL: begin
                if (to_hit)        state_nxt = ST_IDLE;
                else if (!ready_s) state_nxt = ST_WAIT_RISE;
            end
            ST_WAIT_RISE: begin
                if (to_hit)       state_nxt = ST_IDLE;
                else if (ready_s) state_nxt = ST_READ_HI;
            end
            ST_READ_HI: begin
                if (ph_hit) state_nxt = mode_q ? ST_READ_LO : ST_DONE;
            end
            ST_READ_LO: begin
                if (ph_hit) state_nxt = ST_DONE;
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    assign cap_word = (state_q == ST_READ_HI) && ph_hit && !mode_q;
    assign cap_hi   = (state_q == ST_READ_HI) && ph_hit &&  mode_q;
    assign cap_lo   = (state_q == ST_READ_LO) && ph_hit;

    adc_host_assemble #(.BUS_W(BUS_W), .RES_W(RES_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_word_i (cap_word),
        .cap_hi_i   (cap_hi),
        .cap_lo_i   (cap_lo),
        .bus_i      (bus_i),
        .sample_o   (sample_o)
    );

    // Output and flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q    <= PINS_QUIET;
            valid_q   <= 1'b0;
            timeout_q <= 1'b0;
            mode_q    <= 1'b0;
        end else begin
            pins_q  <= pins_for(state_nxt);
            valid_q <= (state_nxt == ST_DONE);
            if (accept) begin
                mode_q    <= byte_mode_i;
                timeout_q <= 1'b0;
            end else if (waiting && to_hit) begin
                timeout_q <= 1'b1;
            end
        end
    end

    assign cs_n_o         = pins_q.cs_n;
    assign rc_o           = pins_q.rc;
    assign byte_sel_o     = pins_q.bsel;
    assign sample_valid_o = valid_q;
    assign timeout_o      = timeout_q;

    assert_sel_high_at_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n_i) |-> (cs_n_o || rc_o));

    assert_read_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && rc_o) |-> ready_s);

    assert_bsel_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sel_o |-> (!cs_n_o && rc_o));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);

    assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rc_o) && !cs_n_o) |-> ($past(state_q) == ST_IDLE));

    assert_timeout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (cs_n_o && rc_o));

endmodule

// File: tb/adc_par_host_tb_top.sv
`timescale 1ns/1ps
module adc_par_host_tb_top;

    localparam int PULSE_W  = 2;
    localparam int SETUP_W  = 2;
    localparam int TO_CYC   = 64;
    localparam int CONV_CYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        free_run_i = 1'b0;
    logic        byte_mode_i = 1'b0;
    logic        busy_n_i;
    logic [15:0] bus_i;
    logic        cs_n_o, rc_o, byte_sel_o;
    logic [11:0] sample_o;
    logic        sample_valid_o, timeout_o;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    adc_par_host #(
        .PULSE_W(PULSE_W), .SETUP_W(SETUP_W), .TIMEOUT_CYC(TO_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
        .byte_mode_i(byte_mode_i), .busy_n_i(busy_n_i), .bus_i(bus_i),
        .cs_n_o(cs_n_o), .rc_o(rc_o), .byte_sel_o(byte_sel_o),
        .sample_o(sample_o), .sample_valid_o(sample_valid_o), .timeout_o(timeout_o)
    );

    // Converter model
    logic [11:0] next_val = 12'h000;
    logic [11:0] held_val, out_val;
    logic        hang = 1'b0;
    logic        prev_cnv, prev_busy;
    int          conv_left;
    int          conv_count = 0;
    int          valid_count = 0;
    int          bsel_cycles = 0;
    int          sel_viol = 0;
    int          rd_viol = 0;
    logic        cnv_now;

    assign cnv_now = !cs_n_o && !rc_o;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy_n_i  <= 1'b1;
            conv_left <= 0;
            prev_cnv  <= 1'b0;
            held_val  <= '0;
            out_val   <= '0;
        end else begin
            if (cnv_now && !prev_cnv && busy_n_i) begin
                busy_n_i   <= 1'b0;
                conv_left  <= CONV_CYC;
                held_val   <= next_val;
                conv_count <= conv_count + 1;
            end else if (!busy_n_i && !hang) begin
                if (conv_left <= 1) begin
                    busy_n_i <= 1'b1;
                    out_val  <= held_val;
                end
                conv_left <= conv_left - 1;
            end
            prev_cnv <= cnv_now;
        end
    end

    always_comb begin
        if (!cs_n_o && rc_o)
            bus_i = byte_sel_o ? {out_val[3:0], 4'h0, out_val[11:4]} : {out_val, 4'h0};
        else
            bus_i = 16'hDEAD;
    end

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid_o) valid_count <= valid_count + 1;
            if (byte_sel_o) bsel_cycles <= bsel_cycles + 1;
            if (busy_n_i && !prev_busy && !cs_n_o && !rc_o) sel_viol <= sel_viol + 1;
            if (!cs_n_o && rc_o && !busy_n_i) rd_viol <= rd_viol + 1;
        end
        prev_busy <= busy_n_i;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_conv(input bit bmode, input logic [11:0] val,
                            output int pw, output logic [11:0] got, output int vlen);
        int guard;
        next_val = val;
        byte_mode_i = bmode;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (!(!rc_o && !cs_n_o) && guard < 50) begin @(negedge clk); guard++; end
        pw = 0;
        while (!rc_o && !cs_n_o) begin pw++; @(negedge clk); end
        guard = 0;
        while (!sample_valid_o && guard < 500) begin @(negedge clk); guard++; end
        got = sample_o;
        vlen = 0;
        while (sample_valid_o && vlen < 10) begin vlen++; @(negedge clk); end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o && rc_o && !byte_sel_o && !sample_valid_o && !timeout_o, "R1 in reset",
            {cs_n_o, rc_o, byte_sel_o, sample_valid_o, timeout_o}, 5'b11000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o && rc_o && !byte_sel_o && !sample_valid_o && !timeout_o, "R1 after reset",
            {cs_n_o, rc_o, byte_sel_o, sample_valid_o, timeout_o}, 5'b11000);
    endtask

    task automatic t_word(input logic [11:0] val);
        int pw, vlen, b0;
        logic [11:0] got;
        b0 = bsel_cycles;
        run_conv(1'b0, val, pw, got, vlen);
        chk(pw == PULSE_W, "R2 pulse width", pw, PULSE_W);
        chk(got == val, "R5 word sample", got, val);
        chk(bsel_cycles == b0, "R5 byte select stays low", bsel_cycles - b0, 0);
        chk(vlen == 1, "R7 valid length", vlen, 1);
    endtask

    task automatic t_byte(input logic [11:0] val);
        int pw, vlen, b0;
        logic [11:0] got;
        b0 = bsel_cycles;
        run_conv(1'b1, val, pw, got, vlen);
        chk(got == val, "R6 byte sample", got, val);
        chk(bsel_cycles - b0 == SETUP_W, "R6 second read length", bsel_cycles - b0, SETUP_W);
        chk(vlen == 1, "R7 valid length byte", vlen, 1);
    endtask

    task automatic t_ignore_start();
        int c0, v0, guard;
        c0 = conv_count;
        v0 = valid_count;
        next_val = 12'h123;
        byte_mode_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (!sample_valid_o && guard < 500) begin @(negedge clk); guard++; end
        repeat (40) @(negedge clk);
        chk(conv_count - c0 == 1, "R8 extra start ignored", conv_count - c0, 1);
        chk(valid_count - v0 == 1, "R8 single result", valid_count - v0, 1);
        chk(cs_n_o && rc_o, "R8 idle after", {cs_n_o, rc_o}, 2'b11);
    endtask

    task automatic t_free_run();
        int c0, v0, guard;
        c0 = conv_count;
        v0 = valid_count;
        next_val = 12'h7E4;
        byte_mode_i = 1'b0;
        free_run_i = 1'b1;
        guard = 0;
        while (valid_count - v0 < 3 && guard < 2000) begin @(negedge clk); guard++; end
        free_run_i = 1'b0;
        chk(valid_count - v0 >= 3, "R9 repeated samples", valid_count - v0, 3);
        chk(sample_o == 12'h7E4, "R9 free-run value", sample_o, 12'h7E4);
        repeat (60) @(negedge clk);
        chk(conv_count - c0 >= 3, "R9 conversions issued", conv_count - c0, 3);
    endtask

    task automatic t_timeout();
        int pw, vlen, guard;
        logic [11:0] got;
        hang = 1'b1;
        next_val = 12'h555;
        byte_mode_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (!rc_o && guard < 20) begin @(negedge clk); guard++; end
        repeat (TO_CYC - 3) @(negedge clk);
        chk(timeout_o == 1'b0, "R10 not early", timeout_o, 0);
        repeat (6) @(negedge clk);
        chk(timeout_o == 1'b1, "R10 flag raised", timeout_o, 1);
        chk(cs_n_o && rc_o, "R10 back to idle", {cs_n_o, rc_o}, 2'b11);
        hang = 1'b0;
        repeat (30) @(negedge clk);
        run_conv(1'b0, 12'h9C6, pw, got, vlen);
        chk(timeout_o == 1'b0, "R10 flag cleared", timeout_o, 0);
        chk(got == 12'h9C6, "R10 recovery sample", got, 12'h9C6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_word(12'h000);
        t_word(12'hFFF);
        t_word(12'h5A3);
        t_byte(12'hA5C);
        t_byte(12'h3F1);
        t_ignore_start();
        t_free_run();
        t_timeout();
        chk(sel_viol == 0, "R3 select high at busy rise", sel_viol, 0);
        chk(rd_viol == 0, "R4 no read while busy", rd_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule